// File: doc/BRIEF.md
# Two-Input Moore Sequence Machine with Selectable State Coding

This block is a five-state Moore machine. It samples two serial inputs, `a_in` and `b_in`, on each rising clock edge and drives one output, `z_out`. The output is a function of the stored state only, so `z_out` changes in the cycle after the edge that moves the machine. The five states are called INIT, A0, A1, OK0 and OK1 below. The output is high exactly in OK0 and OK1.

A parameter chosen at elaboration time sets how the state is stored in flip-flops. There are four choices: a plain binary count, a one-hot code, a one-hot code that stores INIT as all zeros, and a decomposed code whose bits carry meaning. In the decomposed code the top bit marks "left INIT", the middle bit equals the output, and the low bit holds the last value of `a_in`. Every coding drives the same transition table. The behaviour seen at the ports is therefore identical for all four, and instances with different codings can be compared against each other. A stored code that is not one of the five legal codes sends the machine back to INIT on the next edge.

Top module: `ab_seq_fsm`

## Requirements
- R1: While `rst_n` is low the machine is held in INIT and `z_out` is 0. The reset takes effect without waiting for a clock edge.
- R2: `z_out` is 1 exactly when the stored state is OK0 or OK1. It is 0 in INIT, A0 and A1.
- R3: From INIT, an edge with `a_in`=0 moves the machine to A0, and an edge with `a_in`=1 moves it to A1. `b_in` is ignored in INIT.
- R4: From A0, `a_in`=0 moves the machine to OK0 and `a_in`=1 moves it to A1. `b_in` is ignored in A0.
- R5: From A1, `a_in`=0 moves the machine to A0 and `a_in`=1 moves it to OK1. `b_in` is ignored in A1.
- R6: From OK0, `a_in`=0 keeps the machine in OK0 whatever `b_in` is. With `a_in`=1, `b_in`=1 moves it to OK1 and `b_in`=0 moves it to A1.
- R7: From OK1, `a_in`=1 keeps the machine in OK1 whatever `b_in` is. With `a_in`=0, `b_in`=1 moves it to OK0 and `b_in`=0 moves it to A0.
- R8: Parameter `ENC` selects the state coding:
  - 0 is binary: INIT..OK1 = 000, 001, 010, 011, 100.
  - 1 is one-hot, with INIT = 00001.
  - 2 is one-hot with INIT = 0000.
  - 3 is decomposed: INIT=000, A0=100, A1=101, OK0=110, OK1=111.
  
  For any common input stream, all four give the same `z_out` sequence, and after reset the stored code is always a legal one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released in step with `clk` |
| a_in | input | 1 | First serial input, sampled on each rising edge |
| b_in | input | 1 | Second serial input, sampled on each rising edge |
| z_out | output | 1 | Moore output, derived from the stored state |

## Verification
The assertions assume that `a_in` and `b_in` hold known values at every rising edge. They also assume that `rst_n` is released away from a clock edge, so the first edge after reset always starts from INIT. The stimulus meets both assumptions. It changes the inputs and `rst_n` only on falling edges and never leaves an input undriven. The checks then visit every state with every two-bit input, followed by probes that separate states with equal output, and finish with a long random stream. During all of this, four instances with different codings run side by side.

// File: rtl/ab_seq_pkg.sv
package ab_seq_pkg;

  // Abstract state names shared by all codings
  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_A0   = 3'd1,
    ST_A1   = 3'd2,
    ST_OK0  = 3'd3,
    ST_OK1  = 3'd4
  } seq_st_e;

  // State coding choices
  typedef enum logic [1:0] {
    ENC_BINARY = 2'd0,
    ENC_ONEHOT = 2'd1,
    ENC_ALMOST = 2'd2,
    ENC_DECOMP = 2'd3
  } enc_e;

  localparam int unsigned MAX_CODE_W = 5;

  function automatic int unsigned code_width(enc_e e);
    case (e)
      ENC_ONEHOT: return 5;
      ENC_ALMOST: return 4;
      default:    return 3;
    endcase
  endfunction

  // Stored code of an abstract state, right-aligned in MAX_CODE_W bits
  function automatic logic [MAX_CODE_W-1:0] enc_state(enc_e e, seq_st_e s);
    logic [MAX_CODE_W-1:0] c;
    c = '0;
    case (e)
      ENC_BINARY: begin
        case (s)
          ST_A0:   c = 5'b00001;
          ST_A1:   c = 5'b00010;
          ST_OK0:  c = 5'b00011;
          ST_OK1:  c = 5'b00100;
          default: c = 5'b00000;
        endcase
      end
      ENC_ONEHOT: begin
        case (s)
          ST_A0:   c = 5'b00010;
          ST_A1:   c = 5'b00100;
          ST_OK0:  c = 5'b01000;
          ST_OK1:  c = 5'b10000;
          default: c = 5'b00001;
        endcase
      end
      ENC_ALMOST: begin
        case (s)
          ST_A0:   c = 5'b00001;
          ST_A1:   c = 5'b00010;
          ST_OK0:  c = 5'b00100;
          ST_OK1:  c = 5'b01000;
          default: c = 5'b00000;
        endcase
      end
      default: begin
        case (s)
          ST_A0:   c = 5'b00100;
          ST_A1:   c = 5'b00101;
          ST_OK0:  c = 5'b00110;
          ST_OK1:  c = 5'b00111;
          default: c = 5'b00000;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/seq_next_table.sv
module seq_next_table
  import ab_seq_pkg::*;
(
  input  seq_st_e cur_st,
  input  logic    cur_ok,
  input  logic    a_in,
  input  logic    b_in,
  output seq_st_e nxt_st
);

  always_comb begin
    nxt_st = ST_INIT;
    if (cur_ok) begin
      case (cur_st)
        ST_INIT: nxt_st = a_in ? ST_A1 : ST_A0;
        ST_A0:   nxt_st = a_in ? ST_A1 : ST_OK0;
        ST_A1:   nxt_st = a_in ? ST_OK1 : ST_A0;
        ST_OK0: begin
          if (!a_in)     nxt_st = ST_OK0;
          else if (b_in) nxt_st = ST_OK1;
          else           nxt_st = ST_A1;
        end
        ST_OK1: begin
          if (a_in)      nxt_st = ST_OK1;
          else if (b_in) nxt_st = ST_OK0;
          else           nxt_st = ST_A0;
        end
        default: nxt_st = ST_INIT;
      endcase
    end
  end

endmodule

// File: rtl/seq_state_codec.sv
module seq_state_codec
  import ab_seq_pkg::*;
#(
  parameter enc_e        ENC = ENC_BINARY,
  parameter int unsigned W   = 3
) (
  input  seq_st_e        st_in,
  output logic [W-1:0]   code_out,
  input  logic [W-1:0]   code_in,
  output seq_st_e        st_out,
  output logic           code_ok,
  output logic           z_raw
);

  // Encoder: abstract next state to stored code
  assign code_out = W'(enc_state(ENC, st_in));

  // Decoder: stored code to abstract state, legality and output
  generate
    if (ENC == ENC_BINARY) begin : g_bin
      always_comb begin
        code_ok = 1'b1;
        st_out  = ST_INIT;
        case (code_in)
          3'b000:  st_out = ST_INIT;
          3'b001:  st_out = ST_A0;
          3'b010:  st_out = ST_A1;
          3'b011:  st_out = ST_OK0;
          3'b100:  st_out = ST_OK1;
          default: code_ok = 1'b0;
        endcase
      end
      assign z_raw = (code_in == 3'b011) | (code_in == 3'b100);
    end else if (ENC == ENC_ONEHOT) begin : g_oh
      always_comb begin
        code_ok = $onehot(code_in);
        st_out  = ST_INIT;
        if (code_in[1])      st_out = ST_A0;
        else if (code_in[2]) st_out = ST_A1;
        else if (code_in[3]) st_out = ST_OK0;
        else if (code_in[4]) st_out = ST_OK1;
      end
      assign z_raw = code_ok & (code_in[3] | code_in[4]);
    end else if (ENC == ENC_ALMOST) begin : g_ah
      always_comb begin
        code_ok = $onehot0(code_in);
        st_out  = ST_INIT;
        if (code_in[0])      st_out = ST_A0;
        else if (code_in[1]) st_out = ST_A1;
        else if (code_in[2]) st_out = ST_OK0;
        else if (code_in[3]) st_out = ST_OK1;
      end
      assign z_raw = code_ok & (code_in[2] | code_in[3]);
    end else begin : g_dec
      // bit 2: left INIT, bit 1: output, bit 0: last a_in
      always_comb begin
        code_ok = 1'b1;
        st_out  = ST_INIT;
        case (code_in)
          3'b000:  st_out = ST_INIT;
          3'b100:  st_out = ST_A0;
          3'b101:  st_out = ST_A1;
          3'b110:  st_out = ST_OK0;
          3'b111:  st_out = ST_OK1;
          default: code_ok = 1'b0;
        endcase
      end
      assign z_raw = code_in[2] & code_in[1];
    end
  endgenerate

endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg #(
  parameter int unsigned     W        = 3,
  parameter logic [W-1:0]    RST_CODE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_code,
  output logic [W-1:0] q_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_code <= RST_CODE;
    end else begin
      q_code <= d_code;
    end
  end

endmodule

// File: rtl/ab_seq_fsm.sv
module ab_seq_fsm
  import ab_seq_pkg::*;
#(
  parameter enc_e ENC = ENC_BINARY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_in,
  input  logic b_in,
  output logic z_out
);

  localparam int unsigned  W        = code_width(ENC);
  localparam logic [W-1:0] RST_CODE = W'(enc_state(ENC, ST_INIT));

  logic [W-1:0] cur_code;
  logic [W-1:0] nxt_code;
  seq_st_e      cur_st;
  seq_st_e      nxt_st;
  logic         code_ok;
  logic         z_raw;

  seq_state_codec #(
    .ENC (ENC),
    .W   (W)
  ) u_codec (
    .st_in    (nxt_st),
    .code_out (nxt_code),
    .code_in  (cur_code),
    .st_out   (cur_st),
    .code_ok  (code_ok),
    .z_raw    (z_raw)
  );

  seq_next_table u_table (
    .cur_st (cur_st),
    .cur_ok (code_ok),
    .a_in   (a_in),
    .b_in   (b_in),
    .nxt_st (nxt_st)
  );

  seq_state_reg #(
    .W        (W),
    .RST_CODE (RST_CODE)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_code (nxt_code),
    .q_code (cur_code)
  );

  assign z_out = z_raw;

endmodule

// File: rtl/ab_seq_fsm_chk.sv
module ab_seq_fsm_chk
  import ab_seq_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    a_in,
  input logic    b_in,
  input logic    z_out,
  input seq_st_e cur_st,
  input logic    code_ok
);

  AST_RESET_Z_LOW: assert property (@(posedge clk) !rst_n |-> !z_out); // R1
  AST_Z_IN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    z_out == (cur_st == ST_OK0 || cur_st == ST_OK1)); // R2
  AST_INIT_A0: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_INIT && !a_in) |=> cur_st == ST_A0); // R3
  AST_INIT_A1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_INIT && a_in) |=> cur_st == ST_A1); // R3
  AST_A0_OK0: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_A0 && !a_in) |=> cur_st == ST_OK0); // R4
  AST_A0_A1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_A0 && a_in) |=> cur_st == ST_A1); // R4
  AST_A1_A0: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_A1 && !a_in) |=> cur_st == ST_A0); // R5
  AST_A1_OK1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_A1 && a_in) |=> cur_st == ST_OK1); // R5
  AST_OK0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_OK0 && !a_in) |=> cur_st == ST_OK0); // R6
  AST_OK0_OK1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_OK0 && a_in && b_in) |=> cur_st == ST_OK1); // R6
  AST_OK0_A1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_OK0 && a_in && !b_in) |=> cur_st == ST_A1); // R6
  AST_OK1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_OK1 && a_in) |=> cur_st == ST_OK1); // R7
  AST_OK1_OK0: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_OK1 && !a_in && b_in) |=> cur_st == ST_OK0); // R7
  AST_OK1_A0: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_OK1 && !a_in && !b_in) |=> cur_st == ST_A0); // R7
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok); // R8

endmodule

bind ab_seq_fsm ab_seq_fsm_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .b_in    (b_in),
  .z_out   (z_out),
  .cur_st  (cur_st),
  .code_ok (code_ok)
);

// File: tb/ab_seq_fsm_test.sv
`timescale 1ns/1ps
module ab_seq_fsm_test;
  import ab_seq_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic a;
  logic b;
  logic z_bin, z_oh, z_ah, z_dc;

  int n_run  = 0;
  int n_fail = 0;
  int m_st   = 0; // model: 0 INIT, 1 A0, 2 A1, 3 OK0, 4 OK1

  ab_seq_fsm #(.ENC(ENC_BINARY)) uut    (.clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .z_out(z_bin));
  ab_seq_fsm #(.ENC(ENC_ONEHOT)) uut_oh (.clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .z_out(z_oh));
  ab_seq_fsm #(.ENC(ENC_ALMOST)) uut_ah (.clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .z_out(z_ah));
  ab_seq_fsm #(.ENC(ENC_DECOMP)) uut_dc (.clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .z_out(z_dc));

  function automatic int model_next(int s, logic ai, logic bi);
    case (s)
      0:       return ai ? 2 : 1;
      1:       return ai ? 2 : 3;
      2:       return ai ? 4 : 1;
      3:       return !ai ? 3 : (bi ? 4 : 2);
      default: return ai ? 4 : (bi ? 3 : 1);
    endcase
  endfunction

  function automatic logic model_z(int s);
    return (s == 3) || (s == 4);
  endfunction

  task automatic check(string tag);
    logic [3:0] zs;
    zs = {z_dc, z_ah, z_oh, z_bin};
    for (int i = 0; i < 4; i++) begin
      n_run++;
      if (zs[i] !== model_z(m_st)) begin
        n_fail++;
        $display("FAIL %s enc=%0d state=%0d z=%b expected %b", tag, i, m_st, zs[i], model_z(m_st));
      end
    end
  endtask

  task automatic step(logic ai, logic bi, string tag);
    a = ai;
    b = bi;
    @(posedge clk);
    m_st = model_next(m_st, ai, bi);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_st  = 0;
    #1;
    check("R1");
    @(negedge clk);
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
  endtask

  task automatic reach(int s);
    case (s)
      1: step(1'b0, 1'b0, "R3");
      2: step(1'b1, 1'b0, "R3");
      3: begin step(1'b0, 1'b0, "R4"); step(1'b0, 1'b0, "R4"); end
      4: begin step(1'b1, 1'b0, "R5"); step(1'b1, 1'b0, "R5"); end
      default: ;
    endcase
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    string tags[5];
    tags = '{"R3", "R4", "R5", "R6", "R7"};
    rst_n = 1'b0;
    a     = 1'b0;
    b     = 1'b0;
    @(negedge clk);
    do_reset();

    // Every state, every input pair, then probes that separate equal-output states
    for (int s = 0; s < 5; s++) begin
      for (int ab = 0; ab < 4; ab++) begin
        for (int p = 0; p < 3; p++) begin
          do_reset();
          reach(s);
          step(ab[1], ab[0], tags[s]);
          case (p)
            0: begin step(1'b0, 1'b0, tags[s]); step(1'b0, 1'b0, tags[s]); end
            1: begin step(1'b1, 1'b0, tags[s]); step(1'b1, 1'b0, tags[s]); end
            default: begin step(1'b1, 1'b1, tags[s]); step(1'b0, 1'b0, tags[s]); end
          endcase
        end
      end
    end

    // Long random stream: all codings track the model (R2, R8)
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      step(1'($urandom), 1'($urandom), "R8");
      if (k == 2000) do_reset();
    end

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R8 watchdog expired: actual hung, expected completion");
    summary();
  end

endmodule